// File: doc/BRIEF.md
# Decimal Text to Unsigned Binary Converter

The converter takes 8-bit character codes one at a time over a valid/ready handshake and turns a run of decimal digit characters into an unsigned binary number. The run ends at the first character that is not a digit. The converter then emits the number with a one-cycle done pulse and starts the next number from zero. The terminating character is consumed and has no other effect. A number that grows past the output width wraps modulo 2^W.

Each digit is kept pending until the following character shows whether the number goes on. If the number goes on, the running total plus the pending digit is scaled by ten. If the number ends, the pending digit is only added. Scaling by ten uses no multiplier. The sum is doubled, and then the doubled value is added four times, one addition per cycle. The input stalls during those four additions.

Top module: `dec_string_parser`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_value` is 0.
- R2: A character is a digit only when its code lies in 0x30 to 0x39 inclusive. Its value is the code minus 0x30. The codes 0x2F and 0x3A are terminators.
- R3: A digit run followed by a terminator yields the decimal value of the run. For example, "12345" yields 12345, and leading zeros add nothing to the value.
- R4: Each completed number raises `out_valid` for exactly one cycle, with `out_value` holding the result. The pulse appears in the cycle after the terminator is accepted.
- R5: A terminator accepted while no digit is pending produces no pulse and leaves the next number unaffected.
- R6: Accepting a digit while another digit is pending drops `in_ready` for exactly 4 cycles. The final digit of a run causes no stall, so a single digit followed by a terminator never drops `in_ready`.
- R7: The running total is cleared after each delivered number, so consecutive numbers are independent.
- R8: Results wrap modulo 2^16: "65536" yields 0 and "70000" yields 4464.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character code |
| in_ready | output | 1 | Converter can accept a character |
| out_valid | output | 1 | One-cycle done pulse |
| out_value | output | W (16) | Converted number, valid with the pulse |

## Verification
The hardest case to reach is the look-ahead choice itself: whether a digit is scaled depends on the character that comes after it. The stimulus therefore counts stall cycles across strings of one, two and three digits. A single digit must give no stall, and each further digit must give exactly four. Lone terminators, terminators right at the edges of the digit range, and back-to-back numbers show that a pending digit is never scaled by mistake. They also show that a cleared total does not leak into the next result.

// File: rtl/dec_string_parser.sv
module dec_string_parser #(
  parameter int W = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_value
);
  localparam logic [CW-1:0] CODE_LO = CW'(8'h30);
  localparam logic [CW-1:0] CODE_HI = CW'(8'h39);
  localparam int ADDS = 4;
  localparam int SW = $clog2(ADDS);

  typedef enum logic [1:0] {S_EMPTY, S_HELD, S_SCALE} state_t;
  state_t state;

  logic [W-1:0]  total, dbl, sum;
  logic [3:0]    pend;
  logic [SW-1:0] step;
  logic          is_digit, take;
  logic [3:0]    digit;

  assign is_digit = (in_data >= CODE_LO) && (in_data <= CODE_HI);
  assign digit    = 4'(in_data - CODE_LO);
  assign sum      = total + {{(W-4){1'b0}}, pend};
  assign in_ready = (state != S_SCALE);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_EMPTY;
      total     <= '0;
      dbl       <= '0;
      pend      <= '0;
      step      <= '0;
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        S_EMPTY: if (take && is_digit) begin
          pend  <= digit;
          state <= S_HELD;
        end
        S_HELD: if (take) begin
          if (is_digit) begin
            dbl   <= sum << 1;
            total <= sum << 1;
            pend  <= digit;
            step  <= '0;
            state <= S_SCALE;
          end else begin
            out_valid <= 1'b1;
            out_value <= sum;
            total     <= '0;
            pend      <= '0;
            state     <= S_EMPTY;
          end
        end
        S_SCALE: begin
          total <= total + dbl;
          step  <= step + 1'b1;
          if (step == SW'(ADDS - 1)) state <= S_HELD;
        end
        default: state <= S_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/dec_string_parser_chk.sv
module dec_string_parser_chk #(
  parameter int W = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [CW-1:0] in_data,
  input logic          in_ready,
  input logic          out_valid,
  input logic [W-1:0]  out_value
);
  logic [3:0] low_run;
  logic       term_seen;

  assign term_seen = in_valid && in_ready && !((in_data >= CW'(8'h30)) && (in_data <= CW'(8'h39)));

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!in_ready) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  p_stall_len_r6: assert property (@(posedge clk) disable iff (!rst_n) low_run <= 4'd4);
  p_stall_min_r6: assert property (@(posedge clk) disable iff (!rst_n) (!in_ready && low_run < 4'd3) |=> !in_ready);
  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid);
  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(out_valid) |-> $past(term_seen));
  p_no_pulse_stall_r6: assert property (@(posedge clk) disable iff (!rst_n) !in_ready |-> !out_valid);
endmodule

bind dec_string_parser dec_string_parser_chk #(.W(W), .CW(CW)) u_chk (.*);

// File: tb/dec_string_parser_bench.sv
module dec_string_parser_bench;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid;
  logic [15:0] out_value;
  int checks = 0, errors = 0;
  int pulses = 0, low_cycles = 0;
  int last_val = -1;
  bit done = 0;

  always #4 clk = ~clk;

  dec_string_parser u_dec_string_parser (.*);

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin pulses++; last_val = out_value; end
    if (!in_ready) low_cycles++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_str(string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_data = s[i];
      @(negedge clk);
      in_valid = 0;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_mon();
    pulses = 0; low_cycles = 0; last_val = -1;
  endtask

  task automatic one_number(string s, int exp, int stalls, string req);
    clear_mon();
    send_str(s);
    chk(pulses == 1, {req, " pulse count R4"}, pulses, 1);
    chk(last_val == exp, req, last_val, exp);
    chk(low_cycles == stalls, {req, " stall cycles R6"}, low_cycles, stalls);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    chk(out_valid == 0, "R1 valid", out_valid, 0);
    chk(out_value == 0, "R1 value", out_value, 0);
  endtask

  task automatic t_lone_terms();
    clear_mon();
    send_str("x/ :");
    chk(pulses == 0, "R5 no pulse without digit", pulses, 0);
    one_number("42 ", 42, 4, "R5 after lone terminators");
  endtask

  task automatic t_edges();
    one_number("0/", 0, 0, "R2 low edge 0x2F terminates");
    one_number("9:", 9, 0, "R2 high edge 0x3A terminates");
    one_number("90 ", 90, 4, "R2 digits 0x30 and 0x39");
  endtask

  task automatic t_values();
    one_number("12345\n", 12345, 16, "R3 value 12345");
    one_number("007 ", 7, 8, "R3 leading zeros");
    one_number("5,", 5, 0, "R6 single digit no stall");
    one_number("123 ", 123, 8, "R6 three digits two stalls");
  endtask

  task automatic t_back_to_back();
    clear_mon();
    send_str("12x");
    chk(last_val == 12, "R7 first number", last_val, 12);
    clear_mon();
    send_str("34x");
    chk(last_val == 34, "R7 second number independent", last_val, 34);
    chk(pulses == 1, "R7 single pulse", pulses, 1);
  endtask

  task automatic t_wrap();
    one_number("65536 ", 0, 16, "R8 wrap 65536");
    one_number("70000 ", 4464, 16, "R8 wrap 70000");
    one_number("65535 ", 65535, 16, "R8 max value");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lone_terms();
    t_edges();
    t_values();
    t_back_to_back();
    t_wrap();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule